// File: doc/BRIEF.md
# Processor Mode and Exception-Entry Controller

This block keeps the operating mode and the two interrupt-disable bits of a 32-bit RISC core, and turns exception events into mode changes. It watches a fast interrupt request, a normal interrupt request, a memory-abort strobe, an undefined-instruction strobe and a software-interrupt strobe. On each clock edge it picks at most one event by a fixed priority and moves the core into that event's privileged mode. In the same step it asks the register file for two writes. The first stores the pre-entry status word into the target mode's saved-status register. The second stores PC+4 into the target mode's banked link register. It also issues a pulse carrying the vector address that the fetch unit jumps to.

The core's upper status bits (flags and bit 5) arrive on `statusIn`, and the block merges them with its own mode field and mask bits. The result is the current status word. The core's own status-write path, used by exception return and explicit status writes, loads the mode and masks through `statusWrEn`. In User mode that write has no effect, because User mode is unprivileged. Reset puts the core in Supervisor mode. On the first cycle after reset the block issues the reset vector.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rstN` is low, the mode is Supervisor (5'b10011), both mask bits are set, and `lrWrEn`, `spsrWrEn` and `vecValid` are low. In the first cycle after release, exception events and status writes are ignored. One clock later `vecValid` pulses with `vecAddr` = VEC_BASE + 0x00, and no link or saved-status write is made.
- R2: The mode encodings are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. `modeOut` only ever holds one of these. `privileged` is low exactly in User mode.
- R3: Each event has its own target mode and vector offset from VEC_BASE. Abort goes to Abort at 0x10. The fast request goes to FIQ at 0x1C. The normal request goes to IRQ at 0x18. Undefined goes to Undefined at 0x04. The software interrupt goes to Supervisor at 0x08.
- R4: When events coincide, the priority is abort, then fast request, then normal request, then undefined, then software interrupt.
- R5: A fast request is ignored while the F bit (status bit 6) is set. A normal request is ignored while the I bit (status bit 7) is set.
- R6: On entry, `spsrWrEn` pulses with `spsrWrMode` set to the target mode. `spsrWrData` is the pre-entry status word: {statusIn[31:8], I, F, statusIn[5], mode}.
- R7: In the same cycle as the saved-status write, `lrWrEn` pulses with `lrWrMode` set to the target mode and `lrWrData` set to the sampled `pcIn` + 4.
- R8: Every entry sets I. Entry into FIQ also sets F. Every other entry leaves F unchanged.
- R9: A status write in a privileged mode loads the mode from bits 4:0, I from bit 7 and F from bit 6. If bits 4:0 are not a legal mode encoding, the whole write is dropped.
- R10: A status write made in User mode changes neither the mode nor the mask bits.
- R11: If an exception is taken in the same cycle as a status write, the exception wins and the write is dropped.
- R12: Events and writes sampled at one clock edge show on the outputs right after that edge. `lrWrEn`, `spsrWrEn` and `vecValid` are one-cycle pulses per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fiqReq | input | 1 | Fast interrupt request (level) |
| irqReq | input | 1 | Normal interrupt request (level) |
| swiStb | input | 1 | Software-interrupt instruction executed |
| abortStb | input | 1 | Memory access violation |
| undefStb | input | 1 | Undefined instruction |
| statusWrEn | input | 1 | Load mode and masks from `statusIn` |
| pcIn | input | DATA_W | PC of the interrupted instruction |
| statusIn | input | DATA_W | Core status word (upper bits, bit 5, write value) |
| modeOut | output | 5 | Current mode field |
| privileged | output | 1 | High in all modes but User |
| statusOut | output | DATA_W | Current status word |
| lrWrEn | output | 1 | Banked link register write request |
| lrWrMode | output | 5 | Mode bank of the link write |
| lrWrData | output | DATA_W | Return address |
| spsrWrEn | output | 1 | Saved-status register write request |
| spsrWrMode | output | 5 | Mode bank of the saved-status write |
| spsrWrData | output | DATA_W | Saved status word |
| vecValid | output | 1 | Vector address valid pulse |
| vecAddr | output | DATA_W | Exception vector address |

## Verification
The bench builds the block with DATA_W = 32 and VEC_BASE = 0xFFFF0000. A non-zero base shows that every vector is an offset added to the base, and that the reset vector lands on the base itself. With 32-bit status words, random flag bits reach the upper field, so the saved-status word shows whether the merge keeps the core's bits in place. The random walk often writes User mode, which leaves the block locked until the next exception. Because of this, the unprivileged write path and the way exceptions leave User mode are both exercised many times.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } modeT;

  // event sources, index order is priority order (0 highest)
  localparam int NUM_SRC = 5;
  localparam int SRC_ABT = 0;
  localparam int SRC_FIQ = 1;
  localparam int SRC_IRQ = 2;
  localparam int SRC_UND = 3;
  localparam int SRC_SWI = 4;

  localparam int VEC_W = 5;

  typedef struct packed {
    logic             enter;
    logic             boot;
    modeT             target;
    logic [VEC_W-1:0] vecOff;
  } entryStrbT;

  function automatic logic modeLegal(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: modeLegal = 1'b1;
      default:                      modeLegal = 1'b0;
    endcase
  endfunction

  function automatic modeT srcMode(input int s);
    case (s)
      SRC_ABT: srcMode = MODE_ABT;
      SRC_FIQ: srcMode = MODE_FIQ;
      SRC_IRQ: srcMode = MODE_IRQ;
      SRC_UND: srcMode = MODE_UND;
      default: srcMode = MODE_SVC;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] srcVec(input int s);
    case (s)
      SRC_ABT: srcVec = 5'h10;
      SRC_FIQ: srcVec = 5'h1C;
      SRC_IRQ: srcVec = 5'h18;
      SRC_UND: srcVec = 5'h04;
      default: srcVec = 5'h08;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int NUM = 5
) (
  input  logic [NUM-1:0] rawReq,
  input  logic [NUM-1:0] blockMask,
  input  logic           inhibit,
  output logic [NUM-1:0] grant
);

  logic [NUM-1:0] liveReq;
  logic [NUM:0]   taken;

  assign liveReq = rawReq & ~blockMask & {NUM{~inhibit}};
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM; i++) begin : g_chain
    assign grant[i]   = liveReq[i] & ~taken[i];
    assign taken[i+1] = taken[i] | liveReq[i];
  end

endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
  import exc_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      abortStb,
  input  logic      fiqReq,
  input  logic      irqReq,
  input  logic      undefStb,
  input  logic      swiStb,
  input  logic      statusWrEn,
  input  logic [4:0] wrMode,
  input  logic      wrI,
  input  logic      wrF,
  output modeT      curMode,
  output logic      iMask,
  output logic      fMask,
  output entryStrbT strb
);

  logic                bootPend;
  logic [NUM_SRC-1:0]  rawReq;
  logic [NUM_SRC-1:0]  blockMask;
  logic [NUM_SRC-1:0]  grant;
  logic                wrAllowed;

  always_comb begin
    rawReq            = '0;
    rawReq[SRC_ABT]   = abortStb;
    rawReq[SRC_FIQ]   = fiqReq;
    rawReq[SRC_IRQ]   = irqReq;
    rawReq[SRC_UND]   = undefStb;
    rawReq[SRC_SWI]   = swiStb;
    blockMask          = '0;
    blockMask[SRC_FIQ] = fMask;
    blockMask[SRC_IRQ] = iMask;
  end

  exc_prio_sel #(.NUM(NUM_SRC)) u_prio (
    .rawReq   (rawReq),
    .blockMask(blockMask),
    .inhibit  (bootPend),
    .grant    (grant)
  );

  always_comb begin
    strb.enter  = |grant;
    strb.boot   = bootPend;
    strb.target = MODE_SVC;
    strb.vecOff = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (grant[s]) begin
        strb.target = srcMode(s);
        strb.vecOff = srcVec(s);
      end
    end
  end

  assign wrAllowed = statusWrEn && !bootPend && !strb.enter &&
                     (curMode != MODE_USR) && modeLegal(wrMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode  <= MODE_SVC;
      iMask    <= 1'b1;
      fMask    <= 1'b1;
      bootPend <= 1'b1;
    end else begin
      bootPend <= 1'b0;
      if (strb.enter) begin
        curMode <= strb.target;
        iMask   <= 1'b1;
        if (strb.target == MODE_FIQ) fMask <= 1'b1;
      end else if (wrAllowed) begin
        curMode <= modeT'(wrMode);
        iMask   <= wrI;
        fMask   <= wrF;
      end
    end
  end

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rstN)
    strb.enter |=> iMask); // R8
  AST_FIQ_SETS_F: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enter && strb.target == MODE_FIQ) |=> fMask); // R8
  AST_USER_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USR && !strb.enter) |=>
      (curMode == MODE_USR && $stable(iMask) && $stable(fMask))); // R10
  AST_FIQ_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rstN)
    (fMask && !abortStb) |-> !(strb.enter && strb.target == MODE_FIQ)); // R5
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (abortStb && !bootPend) |-> (strb.enter && strb.target == MODE_ABT)); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeLegal(curMode)); // R2

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] VEC_BASE = '0,
  parameter int                RET_OFF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStrbT         strb,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] curStatus,
  output logic              lrWrEn,
  output logic [4:0]        lrWrMode,
  output logic [DATA_W-1:0] lrWrData,
  output logic              spsrWrEn,
  output logic [4:0]        spsrWrMode,
  output logic [DATA_W-1:0] spsrWrData,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecAddr
);

  localparam logic [DATA_W-1:0] RET_INC = DATA_W'(RET_OFF);

  logic [DATA_W-1:0] vecNext;

  assign vecNext = strb.boot ? VEC_BASE : VEC_BASE + DATA_W'(strb.vecOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrWrEn     <= 1'b0;
      lrWrMode   <= '0;
      lrWrData   <= '0;
      spsrWrEn   <= 1'b0;
      spsrWrMode <= '0;
      spsrWrData <= '0;
      vecValid   <= 1'b0;
      vecAddr    <= '0;
    end else begin
      lrWrEn   <= strb.enter;
      spsrWrEn <= strb.enter;
      vecValid <= strb.enter | strb.boot;
      if (strb.enter) begin
        lrWrMode   <= strb.target;
        lrWrData   <= pcIn + RET_INC;
        spsrWrMode <= strb.target;
        spsrWrData <= curStatus;
      end
      if (strb.enter | strb.boot) vecAddr <= vecNext;
    end
  end

  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strb.enter |=> (lrWrEn && lrWrData == $past(pcIn) + RET_INC)); // R7
  AST_SAVE_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    lrWrEn |-> (spsrWrEn && spsrWrMode == lrWrMode && vecValid)); // R7
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (lrWrEn && !strb.enter) |=> !lrWrEn); // R12

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] VEC_BASE = '0,
  parameter int                RET_OFF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic              swiStb,
  input  logic              abortStb,
  input  logic              undefStb,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [4:0]        modeOut,
  output logic              privileged,
  output logic [DATA_W-1:0] statusOut,
  output logic              lrWrEn,
  output logic [4:0]        lrWrMode,
  output logic [DATA_W-1:0] lrWrData,
  output logic              spsrWrEn,
  output logic [4:0]        spsrWrMode,
  output logic [DATA_W-1:0] spsrWrData,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecAddr
);

  modeT      curMode;
  logic      iMask;
  logic      fMask;
  entryStrbT strb;

  exc_mode_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .abortStb  (abortStb),
    .fiqReq    (fiqReq),
    .irqReq    (irqReq),
    .undefStb  (undefStb),
    .swiStb    (swiStb),
    .statusWrEn(statusWrEn),
    .wrMode    (statusIn[4:0]),
    .wrI       (statusIn[7]),
    .wrF       (statusIn[6]),
    .curMode   (curMode),
    .iMask     (iMask),
    .fMask     (fMask),
    .strb      (strb)
  );

  assign statusOut  = {statusIn[DATA_W-1:8], iMask, fMask, statusIn[5], curMode};
  assign modeOut    = curMode;
  assign privileged = (curMode != MODE_USR);

  exc_entry_dp #(
    .DATA_W  (DATA_W),
    .VEC_BASE(VEC_BASE),
    .RET_OFF (RET_OFF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pcIn      (pcIn),
    .curStatus (statusOut),
    .lrWrEn    (lrWrEn),
    .lrWrMode  (lrWrMode),
    .lrWrData  (lrWrData),
    .spsrWrEn  (spsrWrEn),
    .spsrWrMode(spsrWrMode),
    .spsrWrData(spsrWrData),
    .vecValid  (vecValid),
    .vecAddr   (vecAddr)
  );

endmodule

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;

  localparam int          DW   = 32;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fiqReq = 0, irqReq = 0, swiStb = 0, abortStb = 0, undefStb = 0, statusWrEn = 0;
  logic [31:0] pcIn = '0, statusIn = '0;
  logic [4:0]  modeOut, lrWrMode, spsrWrMode;
  logic        privileged, lrWrEn, spsrWrEn, vecValid;
  logic [31:0] statusOut, lrWrData, spsrWrData, vecAddr;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  // model state
  logic [4:0] mMode;
  logic       mI, mF, mBoot;

  always #2 clk = ~clk;

  exc_entry_unit #(.DATA_W(DW), .VEC_BASE(BASE), .RET_OFF(4)) u_exc_entry_unit (
    .clk(clk), .rstN(rstN), .fiqReq(fiqReq), .irqReq(irqReq), .swiStb(swiStb),
    .abortStb(abortStb), .undefStb(undefStb), .statusWrEn(statusWrEn),
    .pcIn(pcIn), .statusIn(statusIn), .modeOut(modeOut), .privileged(privileged),
    .statusOut(statusOut), .lrWrEn(lrWrEn), .lrWrMode(lrWrMode), .lrWrData(lrWrData),
    .spsrWrEn(spsrWrEn), .spsrWrMode(spsrWrMode), .spsrWrData(spsrWrData),
    .vecValid(vecValid), .vecAddr(vecAddr)
  );

  function automatic logic legal(input logic [4:0] m);
    return m == USR || m == FIQ || m == IRQ || m == SVC ||
           m == ABT || m == UND || m == SYS;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: drive, predict, sample after the edge
  task automatic step(input logic abt, input logic fiq, input logic irq,
                      input logic und, input logic swi, input logic wr,
                      input logic [31:0] pc, input logic [31:0] st, input string tag);
    logic took;
    logic [4:0] tgt;
    logic [31:0] off, expSave;
    abortStb = abt; fiqReq = fiq; irqReq = irq; undefStb = und; swiStb = swi;
    statusWrEn = wr; pcIn = pc; statusIn = st;
    took = 1'b1; tgt = SVC; off = 32'h08;
    if (mBoot)              took = 1'b0;
    else if (abt)           begin tgt = ABT; off = 32'h10; end
    else if (fiq && !mF)    begin tgt = FIQ; off = 32'h1C; end
    else if (irq && !mI)    begin tgt = IRQ; off = 32'h18; end
    else if (und)           begin tgt = UND; off = 32'h04; end
    else if (swi)           begin tgt = SVC; off = 32'h08; end
    else                    took = 1'b0;
    expSave = {st[31:8], mI, mF, st[5], mMode};
    @(posedge clk);
    @(negedge clk);
    if (took) begin
      mMode = tgt; mI = 1'b1;
      if (tgt == FIQ) mF = 1'b1;
    end else if (wr && !mBoot && mMode != USR && legal(st[4:0])) begin
      mMode = st[4:0]; mI = st[7]; mF = st[6];
    end
    chk(tag, "mode", {27'd0, modeOut}, {27'd0, mMode});
    chk("R8", "masks", {30'd0, statusOut[7:6]}, {30'd0, mI, mF});
    chk("R2", "privileged", {31'd0, privileged}, {31'd0, mMode != USR});
    chk("R12", "lrWrEn", {31'd0, lrWrEn}, {31'd0, took});
    chk("R6", "spsrWrEn", {31'd0, spsrWrEn}, {31'd0, took});
    chk("R3", "vecValid", {31'd0, vecValid}, {31'd0, took | mBoot});
    if (took) begin
      chk("R7", "lrWrData", lrWrData, pc + 32'd4);
      chk("R7", "lrWrMode", {27'd0, lrWrMode}, {27'd0, tgt});
      chk("R6", "spsrWrData", spsrWrData, expSave);
      chk("R6", "spsrWrMode", {27'd0, spsrWrMode}, {27'd0, tgt});
      chk("R3", "vecAddr", vecAddr, BASE + off);
    end else if (mBoot) begin
      chk("R1", "reset vecAddr", vecAddr, BASE);
    end
    mBoot = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mMode = SVC; mI = 1'b1; mF = 1'b1; mBoot = 1'b1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset mode", {27'd0, modeOut}, {27'd0, SVC});
    chk("R1", "reset masks", {30'd0, statusOut[7:6]}, 32'd3);
    chk("R1", "reset strobes", {29'd0, lrWrEn, spsrWrEn, vecValid}, 32'd0);
    rstN = 1'b1;
    // R1: first cycle ignores events and writes
    step(1, 1, 1, 1, 1, 1, 32'h100, 32'h0000_0010, "R1");
    // R4: everything at once, abort first
    step(1, 1, 1, 1, 1, 0, 32'h200, 32'hF000_0020, "R4");
    // R9: privileged write to Supervisor with masks clear
    step(0, 0, 0, 0, 0, 1, 32'h204, 32'hA000_0013, "R9");
    // R4: fast beats normal, undefined, swi
    step(0, 1, 1, 1, 1, 0, 32'h300, 32'h5000_0000, "R4");
    step(0, 0, 0, 0, 0, 1, 32'h304, 32'h0000_001F, "R9");
    // R4: normal beats undefined and swi; F stays clear (R8)
    step(0, 0, 1, 1, 1, 0, 32'h400, 32'h1234_5600, "R4");
    // R5: both masks set, requests ignored
    step(0, 0, 0, 0, 0, 1, 32'h404, 32'h0000_00D3, "R9");
    step(0, 1, 1, 0, 0, 0, 32'h408, 32'h0, "R5");
    step(0, 1, 1, 1, 1, 0, 32'h40C, 32'h0, "R4");
    // R5: F set, I clear: normal request taken
    step(0, 0, 0, 0, 0, 1, 32'h410, 32'h0000_0053, "R9");
    step(0, 1, 1, 0, 0, 0, 32'h414, 32'h0, "R5");
    // R9: illegal mode field drops the write
    step(0, 0, 0, 0, 0, 1, 32'h418, 32'h0000_0014, "R9");
    // R2 / R10: drop to User, then a write is ignored
    step(0, 0, 0, 0, 0, 1, 32'h41C, 32'h8000_0010, "R2");
    step(0, 0, 0, 0, 0, 1, 32'h420, 32'h0000_00D3, "R10");
    // R6: swi from User saves the User status word
    step(0, 0, 0, 0, 1, 0, 32'h424, 32'h6000_0020, "R6");
    // R11: exception beats a same-cycle write
    step(0, 0, 0, 1, 0, 1, 32'h500, 32'h0000_001F, "R11");
    // R3: lone software interrupt
    step(0, 0, 0, 0, 1, 0, 32'h504, 32'h0, "R3");
    // random walk
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] st;
      logic [4:0] pick;
      st = $urandom;
      case ($urandom_range(0, 7))
        0: pick = USR; 1: pick = FIQ; 2: pick = IRQ; 3: pick = SVC;
        4: pick = ABT; 5: pick = UND; 6: pick = SYS; default: pick = st[4:0];
      endcase
      st[4:0] = pick;
      step($urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
           {$urandom, 2'b00} & 32'hFFFF_FFFC, st, "R12");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule